// File: doc/BRIEF.md
# Almost-Flag Offset Loader

This block sets up the two threshold values a FIFO needs for its almost-empty and almost-full flags. The almost-empty threshold (`ofs_empty`) and the almost-full threshold (`ofs_full`) are each `OFS_W` bits wide, 9 by default. While reset is held, two dual-purpose configuration pins pick one of four loading methods:
- both thresholds set to a fixed preset of 64 or of 8;
- the thresholds captured from the first two data writes;
- the thresholds shifted in one bit at a time on the configuration pins.

Until loading is finished, the block holds the FIFO's input-ready output low, or steers writes away from memory. It sits in the write-clock domain of the FIFO. The memory and the flag comparison are outside it. Values 1 to 508 are the useful range. The block passes on whatever it is given and does not check it.

State machine (`afl_fsm`), states and transitions:
- `ST_RESET` is held while `rst_n` is low. On the first edge with `rst_n` high it goes to `ST_SHIFT` in serial mode, and to `ST_SETTLE` otherwise.
- `ST_SETTLE` goes to `ST_READY` in a preset mode, loading the preset. In parallel mode it goes to `ST_LOAD_Y`.
- `ST_LOAD_Y` goes to `ST_LOAD_X` on a write.
- `ST_LOAD_X` goes to `ST_READY` on a write.
- `ST_SHIFT` goes to `ST_SHIFT_END` on the edge that takes the last serial bit.
- `ST_SHIFT_END` goes to `ST_READY`, copying the shifted word.
- `ST_READY` is held until the next reset.

Top module: `afl_offset_loader`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `prog_done` and `mem_wr` are 0, and both thresholds read 0.
- R2: The mode is the value of {`cfg_sel1_sen_n`, `cfg_sel0_sdata`} at the last rising edge with `rst_n` low: 2'b11 serial, 2'b10 preset 64, 2'b01 preset 8, 2'b00 parallel.
- R3: In a preset mode, `in_ready` and `prog_done` stay 0 after the first rising edge following reset release. They become 1 after the second edge, and both thresholds equal the preset from that edge on.
- R4: In parallel mode, `in_ready` becomes 1 after the second rising edge following release, while `prog_done` stays 0.
- R5: In parallel mode, the first write (`wr_req`=1 with `in_ready`=1) loads `ofs_full` from `wr_data_lo` (bit `OFS_W-1` is the MSB), and the second write loads `ofs_empty`. Idle cycles may separate the two writes. Neither write raises `mem_wr`. `prog_done` rises on the edge of the second write.
- R6: Once `prog_done` is 1, `mem_wr` equals `wr_req` in the same cycle.
- R7: In serial mode, `cfg_sel0_sdata` is taken on each rising edge with `cfg_sel1_sen_n` low, starting at the second edge after release. Gaps between bits are allowed. Of the 18 bits, the first is the MSB of `ofs_full`, and the last is the LSB of `ofs_empty`.
- R8: In serial mode, `in_ready` stays 0 after the edge that takes the 18th bit, and `mem_wr` stays 0 for writes made in that time. `in_ready`, `prog_done` and both thresholds take effect on the following edge.
- R9: After `prog_done`, activity on `cfg_sel1_sen_n` and `cfg_sel0_sdata` leaves both thresholds unchanged until the next reset.
- R10: Once `in_ready` is 1, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_sel1_sen_n | input | 1 | Mode select high bit during reset; serial enable (active low) afterwards |
| cfg_sel0_sdata | input | 1 | Mode select low bit during reset; serial data afterwards |
| wr_req | input | 1 | Write attempt from the port |
| wr_data_lo | input | OFS_W | Low data bits of the write |
| in_ready | output | 1 | Input ready, held low until loading allows writes |
| prog_done | output | 1 | Both thresholds are final |
| mem_wr | output | 1 | Write is passed to FIFO memory |
| ofs_empty | output | OFS_W | Almost-empty threshold |
| ofs_full | output | OFS_W | Almost-full threshold |

## Verification
The hardest situation to reach is the serial window. There the 18th bit has been taken, but `in_ready` is still low for one more cycle, so a write attempted in that cycle must be refused. The bench reaches it by spreading the bits over irregular gaps, counting them itself, and attempting a write right after the last bit. It then checks that the thresholds arrive one edge later. The bench also pushes a full further set of serial bits after completion to show the values are frozen.

// File: rtl/afl_pkg.sv
package afl_pkg;
    typedef enum logic [2:0] {
        ST_RESET,
        ST_SETTLE,
        ST_LOAD_Y,
        ST_LOAD_X,
        ST_SHIFT,
        ST_SHIFT_END,
        ST_READY
    } afl_state_e;

    typedef enum logic [1:0] {
        MD_PARALLEL  = 2'b00,
        MD_PRESET_LO = 2'b01,
        MD_PRESET_HI = 2'b10,
        MD_SERIAL    = 2'b11
    } afl_mode_e;
endpackage

// File: rtl/afl_fsm.sv
module afl_fsm
    import afl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  afl_mode_e  mode,
    input  logic       last_bit,
    input  logic       wr_req,
    output afl_state_e state,
    output logic       in_rdy,
    output logic       done,
    output logic       ld_preset,
    output logic       ld_y_par,
    output logic       ld_x_par,
    output logic       ld_ser,
    output logic       sh_en,
    output logic       mem_wr
);
    afl_state_e nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET:     nxt = (mode == MD_SERIAL) ? ST_SHIFT : ST_SETTLE;
            ST_SETTLE:    nxt = (mode == MD_PARALLEL) ? ST_LOAD_Y : ST_READY;
            ST_LOAD_Y:    if (wr_req) nxt = ST_LOAD_X;
            ST_LOAD_X:    if (wr_req) nxt = ST_READY;
            ST_SHIFT:     if (last_bit) nxt = ST_SHIFT_END;
            ST_SHIFT_END: nxt = ST_READY;
            ST_READY:     nxt = ST_READY;
            default:      nxt = ST_RESET;
        endcase
    end

    // outputs
    always_comb begin
        in_rdy    = 1'b0;
        done      = 1'b0;
        ld_preset = 1'b0;
        ld_y_par  = 1'b0;
        ld_x_par  = 1'b0;
        ld_ser    = 1'b0;
        sh_en     = 1'b0;
        mem_wr    = 1'b0;
        unique case (state)
            ST_RESET:     ;
            ST_SETTLE:    ld_preset = (mode != MD_PARALLEL);
            ST_LOAD_Y: begin
                in_rdy   = 1'b1;
                ld_y_par = wr_req;
            end
            ST_LOAD_X: begin
                in_rdy   = 1'b1;
                ld_x_par = wr_req;
            end
            ST_SHIFT:     sh_en  = 1'b1;
            ST_SHIFT_END: ld_ser = 1'b1;
            ST_READY: begin
                in_rdy = 1'b1;
                done   = 1'b1;
                mem_wr = wr_req;
            end
            default:      ;
        endcase
    end

    p_rdy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_rdy |=> in_rdy);
endmodule

// File: rtl/afl_shifter.sv
module afl_shifter #(
    parameter int OFS_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sh_en,
    input  logic               sen_n,
    input  logic               sdata,
    output logic [2*OFS_W-1:0] word,
    output logic               last_bit,
    output logic               all_in
);
    localparam int NB = 2 * OFS_W;
    localparam int CW = $clog2(NB + 1);

    logic [CW-1:0] cnt;
    logic          take;

    assign take     = sh_en && !sen_n;
    assign last_bit = take && (cnt == CW'(NB - 1));
    assign all_in   = (cnt == CW'(NB));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            word <= '0;
        end else if (take && !all_in) begin
            cnt  <= cnt + 1'b1;
            word <= {word[NB-2:0], sdata};
        end
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        all_in |=> all_in);
endmodule

// File: rtl/afl_regs.sv
module afl_regs #(
    parameter int OFS_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_preset,
    input  logic [OFS_W-1:0]   preset_val,
    input  logic               ld_y_par,
    input  logic               ld_x_par,
    input  logic [OFS_W-1:0]   par_val,
    input  logic               ld_ser,
    input  logic [2*OFS_W-1:0] ser_word,
    output logic [OFS_W-1:0]   ofs_x,
    output logic [OFS_W-1:0]   ofs_y
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_x <= '0;
            ofs_y <= '0;
        end else begin
            if (ld_preset) begin
                ofs_x <= preset_val;
                ofs_y <= preset_val;
            end
            if (ld_y_par) ofs_y <= par_val;
            if (ld_x_par) ofs_x <= par_val;
            if (ld_ser) begin
                ofs_y <= ser_word[2*OFS_W-1:OFS_W];
                ofs_x <= ser_word[OFS_W-1:0];
            end
        end
    end

    p_one_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_preset, ld_y_par, ld_x_par, ld_ser}));
endmodule

// File: rtl/afl_offset_loader.sv
module afl_offset_loader
    import afl_pkg::*;
#(
    parameter int OFS_W     = 9,
    parameter int PRESET_HI = 64,
    parameter int PRESET_LO = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sel1_sen_n,
    input  logic             cfg_sel0_sdata,
    input  logic             wr_req,
    input  logic [OFS_W-1:0] wr_data_lo,
    output logic             in_ready,
    output logic             prog_done,
    output logic             mem_wr,
    output logic [OFS_W-1:0] ofs_empty,
    output logic [OFS_W-1:0] ofs_full
);
    localparam int NB = 2 * OFS_W;

    afl_mode_e        mode_q;
    afl_state_e       state;
    logic             last_bit, all_in;
    logic             ld_preset, ld_y_par, ld_x_par, ld_ser, sh_en;
    logic [NB-1:0]    ser_word;
    logic [OFS_W-1:0] preset_val;

    // mode pins sampled on every clock while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= afl_mode_e'({cfg_sel1_sen_n, cfg_sel0_sdata});
    end

    assign preset_val = (mode_q == MD_PRESET_HI) ? OFS_W'(PRESET_HI)
                                                 : OFS_W'(PRESET_LO);

    afl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .last_bit  (last_bit),
        .wr_req    (wr_req),
        .state     (state),
        .in_rdy    (in_ready),
        .done      (prog_done),
        .ld_preset (ld_preset),
        .ld_y_par  (ld_y_par),
        .ld_x_par  (ld_x_par),
        .ld_ser    (ld_ser),
        .sh_en     (sh_en),
        .mem_wr    (mem_wr)
    );

    afl_shifter #(.OFS_W(OFS_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sh_en    (sh_en),
        .sen_n    (cfg_sel1_sen_n),
        .sdata    (cfg_sel0_sdata),
        .word     (ser_word),
        .last_bit (last_bit),
        .all_in   (all_in)
    );

    afl_regs #(.OFS_W(OFS_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_preset  (ld_preset),
        .preset_val (preset_val),
        .ld_y_par   (ld_y_par),
        .ld_x_par   (ld_x_par),
        .par_val    (wr_data_lo),
        .ld_ser     (ld_ser),
        .ser_word   (ser_word),
        .ofs_x      (ofs_empty),
        .ofs_y      (ofs_full)
    );

    p_serial_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_SERIAL && !all_in) |-> !in_ready);

    p_ofs_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |=> $stable({ofs_empty, ofs_full}));

    p_mem_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD_Y || state == ST_LOAD_X) |-> !mem_wr);
endmodule

// File: tb/sim_afl_offset_loader.sv
`timescale 1ns/1ps
module sim_afl_offset_loader;
    localparam int W = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sen_n = 1'b1, sdat = 1'b1;
    logic         wr_req = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         in_ready, prog_done, mem_wr;
    logic [W-1:0] ofs_empty, ofs_full;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    afl_offset_loader u0 (
        .clk(clk), .rst_n(rst_n), .cfg_sel1_sen_n(sen_n), .cfg_sel0_sdata(sdat),
        .wr_req(wr_req), .wr_data_lo(wr_data), .in_ready(in_ready),
        .prog_done(prog_done), .mem_wr(mem_wr), .ofs_empty(ofs_empty), .ofs_full(ofs_full)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [1:0] md);
        rst_n = 1'b0; wr_req = 1'b0;
        {sen_n, sdat} = md;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R1 in_ready", in_ready, 0);
            chk("R1 done", prog_done, 0);
            chk("R1 thresholds", {ofs_empty, ofs_full}, 0);
        end
        rst_n = 1'b1;
        tick();                       // edge 1 after release
        {sen_n, sdat} = 2'b11;
        chk("R3/R4/R8 in_ready low after first edge", in_ready, 0);
    endtask

    task automatic preset_case(input logic [1:0] md, input int val);
        do_reset(md);
        tick();                       // edge 2
        chk("R3 in_ready", in_ready, 1);
        chk("R3 done", prog_done, 1);
        chk("R2/R3 ofs_empty", ofs_empty, val);
        chk("R2/R3 ofs_full", ofs_full, val);
        wr_req = 1'b1; #1;
        chk("R6 mem_wr", mem_wr, 1);
        wr_req = 1'b0; #1;
        chk("R6 mem_wr idle", mem_wr, 0);
    endtask

    task automatic parallel_case(input int y, input int x, input int gap);
        do_reset(2'b00);
        tick();
        chk("R4 in_ready", in_ready, 1);
        chk("R4 done", prog_done, 0);
        wr_req = 1'b1; wr_data = W'(y); #1;
        chk("R5 no mem_wr on Y write", mem_wr, 0);
        tick();
        wr_req = 1'b0;
        chk("R5 ofs_full", ofs_full, y);
        chk("R5 done after Y", prog_done, 0);
        for (int i = 0; i < gap; i++) tick();
        chk("R5 ofs_full held over gap", ofs_full, y);
        wr_req = 1'b1; wr_data = W'(x); #1;
        chk("R5 no mem_wr on X write", mem_wr, 0);
        tick();
        wr_req = 1'b0;
        chk("R5 ofs_empty", ofs_empty, x);
        chk("R5 ofs_full kept", ofs_full, y);
        chk("R5 done", prog_done, 1);
        wr_req = 1'b1; wr_data = '1; #1;
        chk("R6 mem_wr", mem_wr, 1);
        tick();
        wr_req = 1'b0;
        chk("R6 data write leaves thresholds", {ofs_full, ofs_empty}, (y << W) | x);
        chk("R10 in_ready stays", in_ready, 1);
    endtask

    task automatic send_bits(input int word, input int gapseed);
        for (int b = 2*W-1; b >= 0; b--) begin
            for (int g = 0; g < ((b + gapseed) % 3); g++) begin
                sen_n = 1'b1; sdat = ~sdat;
                tick();
            end
            sen_n = 1'b0; sdat = word[b];
            tick();
        end
        sen_n = 1'b1;
    endtask

    task automatic serial_case(input int y, input int x, input int gapseed);
        int word;
        word = (y << W) | x;
        do_reset(2'b11);
        send_bits(word, gapseed);
        chk("R8 in_ready low after last bit", in_ready, 0);
        chk("R8 done low after last bit", prog_done, 0);
        wr_req = 1'b1; #1;
        chk("R8 write refused", mem_wr, 0);
        tick();
        wr_req = 1'b0;
        chk("R8 in_ready", in_ready, 1);
        chk("R8 done", prog_done, 1);
        chk("R7 ofs_full", ofs_full, y);
        chk("R7 ofs_empty", ofs_empty, x);
        send_bits(~word, gapseed + 1);
        chk("R9 thresholds frozen", {ofs_full, ofs_empty}, word);
        chk("R10 in_ready stays", in_ready, 1);
    endtask

    initial begin
        preset_case(2'b10, 64);
        preset_case(2'b01, 8);
        parallel_case(1, 508, 0);
        parallel_case(508, 1, 3);
        parallel_case(341, 170, 1);
        parallel_case(256, 255, 2);
        serial_case(1, 508, 0);
        serial_case(508, 1, 1);
        serial_case(341, 170, 2);
        serial_case(257, 3, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule